// File: doc/BRIEF.md
# DRAM Rank Refresh Scheduler

This block sits inside a DRAM controller and turns refresh demand into short command sequences aimed at one rank at a time. Demand comes from one of two sources. In internal mode a free-running refresh-interval timer adds one pending refresh to every rank each time it expires. In user mode, fabric logic supplies the demand through one asynchronous four-phase request/acknowledge pair per rank. Each accepted request adds exactly one refresh to that rank's pending counter.

A rank with pending work is serviced in fixed round-robin order. The scheduler first raises that rank's bit in the access-block vector and holds it for a drain period. It then issues a precharge-all, waits the precharge time, issues a refresh, and waits the refresh cycle time. At the end it lowers the block bit and removes one refresh from the counter. Read/write auto-precharge is never used to close banks early.

After a refresh that was requested in user mode, a short ZQ calibration is scheduled one ZQ interval later, unless a calibration-block input is high when it falls due. The mode register follows its control input only while refresh is disabled, so any change of mode is made inside a disable / switch / re-enable sequence.

Top module: `rank_refresh_sched`

## Requirements
- R1: During and right after reset, `cmd_valid`, `rank_block` and `usr_ack` are all zero, and the mode is internal, so `usr_ready` is low.
- R2: `usr_ready` is high exactly when `cal_done` is high and the latched mode is user.
- R3: While `usr_ready` is high, a rising `usr_req[r]` makes `usr_ack[r]` rise within 16 clock cycles. It also adds one pending refresh to rank r, which leads to exactly one refresh sequence for rank r.
- R4: `usr_ack[r]` falls only after `usr_req[r]` has been deasserted. Holding a request high after its acknowledge adds no further refreshes.
- R5: While `usr_ready` is low, requests get no acknowledge and cause no commands.
- R6: A refresh of rank r is the ordered sequence: `rank_block[r]` rises, PREA to r, REF to r, then `rank_block[r]` falls. The command codes are `cmd_op` = 1 for PREA, 2 for REF and 3 for ZQ short calibration, and `cmd_rank` holds the rank number. At most one `rank_block` bit is high at a time.
- R7: Ranks with pending refreshes are serviced in round-robin order. The search starts at the rank after the last one serviced, and the first rank searched after reset is rank 0.
- R8: Each pending counter saturates at 7. Nine requests accepted while refresh is disabled produce exactly seven refreshes once refresh is enabled.
- R9: In internal mode with refresh enabled, every TREFI_CYC cycles adds one pending refresh to every rank, and no ZQ commands are issued. In user mode there is no interval-driven demand.
- R10: A change of `cfg_user_mode` while `cfg_ref_en` is high is ignored. The latched mode follows the input only while `cfg_ref_en` is low.
- R11: After a user-mode REF to rank r, a ZQ command (code 3) to rank r is issued once ZQ_CYC cycles have passed and the scheduler is idle. It is issued before any later refresh. If `zq_block` is high when the ZQ falls due, that ZQ is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ref_en | input | 1 | Refresh enable control bit |
| cfg_user_mode | input | 1 | Mode select, 1 = user, 0 = internal; latched only while refresh is disabled |
| cal_done | input | 1 | Calibration complete |
| zq_block | input | 1 | Suppress deferred ZQ calibration |
| usr_req | input | NUM_RANKS | Asynchronous per-rank refresh requests |
| usr_ack | output | NUM_RANKS | Per-rank acknowledges |
| usr_ready | output | 1 | User request port available |
| rank_block | output | NUM_RANKS | Per-rank access block |
| cmd_valid | output | 1 | Command strobe, one cycle per command |
| cmd_op | output | 2 | Command code: 1 PREA, 2 REF, 3 ZQ short calibration |
| cmd_rank | output | RANK_W | Target rank of the command |

## Verification
A request driven on a falling edge passes through two synchronizer flops. The acknowledge register is set on the third rising edge, and the bench watches for it at falling edges, allowing at most 16. Command timing depends on the gate, precharge, refresh and ZQ counters, so the bench does not tie commands to fixed cycles. It pushes the expected (code, rank) pairs in the order the requirements dictate, and a monitor pops one pair on every falling edge where `cmd_valid` is high, checking that the rank's block bit is set for PREA and REF. Phases end with a wait longer than the worst-case sequence time, followed by a check that nothing is left unissued and nothing extra appeared.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PREA = 2'd1,
    OP_REF  = 2'd2,
    OP_ZQS  = 2'd3
  } rfs_op_e;

  // Saturating up/down step of a pending-refresh count.
  function automatic int unsigned sat_step(int unsigned cur, logic up, logic down,
                                           int unsigned top);
    int unsigned nxt;
    nxt = cur;
    if (up && !down) nxt = (cur >= top) ? top : cur + 1;
    else if (down && !up) nxt = (cur == 0) ? 0 : cur - 1;
    return nxt;
  endfunction

endpackage

// File: rtl/rfs_req_port.sv
module rfs_req_port (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  input  logic ready,
  output logic ack,
  output logic inc_pulse
);
  logic s1_q, s2_q, ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      s1_q <= req_async;
      s2_q <= s1_q;
      if (!ack_q && s2_q && ready) ack_q <= 1'b1;
      else if (ack_q && !s2_q)     ack_q <= 1'b0;
    end
  end

  assign inc_pulse = !ack_q && s2_q && ready;
  assign ack       = ack_q;
endmodule

// File: rtl/rfs_pend_cnt.sv
module rfs_pend_cnt #(
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RANKS-1:0] inc,
  input  logic [NUM_RANKS-1:0] dec,
  output logic [NUM_RANKS-1:0] pend_mask
);
  import rfs_pkg::*;
  localparam int unsigned CMAX = (1 << CNT_W) - 1;

  logic [NUM_RANKS-1:0][CNT_W-1:0] cnt_q;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[r] <= '0;
      else        cnt_q[r] <= CNT_W'(sat_step(32'(cnt_q[r]), inc[r], dec[r], CMAX));
    end
    assign pend_mask[r] = |cnt_q[r];
  end
endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2,
  parameter int GATE_CYC  = 4,
  parameter int TRP_CYC   = 6,
  parameter int TRFC_CYC  = 40,
  parameter int ZQ_CYC    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 user_mode,
  input  logic                 zq_block,
  input  logic [NUM_RANKS-1:0] pend_mask,
  output logic [NUM_RANKS-1:0] dec,
  output logic [NUM_RANKS-1:0] block,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_op,
  output logic [RANK_W-1:0]    cmd_rank,
  output logic                 ref_evt,
  output logic                 zq_evt
);
  import rfs_pkg::*;

  localparam int M1   = (GATE_CYC > TRP_CYC) ? GATE_CYC : TRP_CYC;
  localparam int M2   = (TRFC_CYC > ZQ_CYC) ? TRFC_CYC : ZQ_CYC;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {S_IDLE, S_GATE, S_RP, S_RFC} seq_st_e;

  seq_st_e           st_q;
  logic [TW-1:0]     tmr_q;
  logic [RANK_W-1:0] cur_q, last_q;
  logic [TW-1:0]     zq_tmr_q;
  logic              zq_arm_q, zq_due_q;
  logic [RANK_W-1:0] zq_rank_q;
  logic              start_evt, done_evt, prea_evt;

  function automatic logic [RANK_W-1:0] rr_pick(logic [NUM_RANKS-1:0] m,
                                                logic [RANK_W-1:0] last);
    logic [RANK_W-1:0] p;
    p = last;
    for (int k = NUM_RANKS; k >= 1; k--) begin
      int idx;
      idx = (int'(last) + k) % NUM_RANKS;
      if (m[idx]) p = RANK_W'(idx);
    end
    return p;
  endfunction

  assign zq_evt    = (st_q == S_IDLE) && zq_due_q && !zq_block && run;
  assign start_evt = (st_q == S_IDLE) && !zq_due_q && run && (|pend_mask);
  assign prea_evt  = (st_q == S_GATE) && (tmr_q == '0);
  assign ref_evt   = (st_q == S_RP)   && (tmr_q == '0);
  assign done_evt  = (st_q == S_RFC)  && (tmr_q == '0);
  assign dec       = done_evt ? (NUM_RANKS'(1) << cur_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      tmr_q     <= '0;
      cur_q     <= '0;
      last_q    <= RANK_W'(NUM_RANKS - 1);
      block     <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_rank  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      unique case (st_q)
        S_IDLE: begin
          if (zq_evt) begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_ZQS;
            cmd_rank  <= zq_rank_q;
          end else if (start_evt) begin
            cur_q <= rr_pick(pend_mask, last_q);
            block <= NUM_RANKS'(1) << rr_pick(pend_mask, last_q);
            tmr_q <= TW'(GATE_CYC - 1);
            st_q  <= S_GATE;
          end
        end
        S_GATE: begin
          if (prea_evt) begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_PREA;
            cmd_rank  <= cur_q;
            tmr_q     <= TW'(TRP_CYC - 1);
            st_q      <= S_RP;
          end else tmr_q <= tmr_q - 1'b1;
        end
        S_RP: begin
          if (ref_evt) begin
            cmd_valid <= 1'b1;
            cmd_op    <= OP_REF;
            cmd_rank  <= cur_q;
            tmr_q     <= TW'(TRFC_CYC - 1);
            st_q      <= S_RFC;
          end else tmr_q <= tmr_q - 1'b1;
        end
        S_RFC: begin
          if (done_evt) begin
            block  <= '0;
            last_q <= cur_q;
            st_q   <= S_IDLE;
          end else tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // Deferred ZQ short calibration after a user-mode refresh.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zq_arm_q  <= 1'b0;
      zq_due_q  <= 1'b0;
      zq_tmr_q  <= '0;
      zq_rank_q <= '0;
    end else begin
      if (ref_evt && user_mode) begin
        zq_arm_q  <= 1'b1;
        zq_tmr_q  <= TW'(ZQ_CYC - 1);
        zq_rank_q <= cur_q;
      end else if (zq_arm_q) begin
        if (zq_tmr_q == '0) begin
          zq_arm_q <= 1'b0;
          zq_due_q <= 1'b1;
        end else zq_tmr_q <= zq_tmr_q - 1'b1;
      end
      if ((st_q == S_IDLE) && zq_due_q && (zq_block || run)) zq_due_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rank_refresh_sched.sv
module rank_refresh_sched #(
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 3,
  parameter int TREFI_CYC = 7800,
  parameter int GATE_CYC  = 4,
  parameter int TRP_CYC   = 6,
  parameter int TRFC_CYC  = 40,
  parameter int ZQ_CYC    = 64,
  parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_ref_en,
  input  logic                 cfg_user_mode,
  input  logic                 cal_done,
  input  logic                 zq_block,
  input  logic [NUM_RANKS-1:0] usr_req,
  output logic [NUM_RANKS-1:0] usr_ack,
  output logic                 usr_ready,
  output logic [NUM_RANKS-1:0] rank_block,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_op,
  output logic [RANK_W-1:0]    cmd_rank
);
  localparam int IW = $clog2(TREFI_CYC + 1);

  logic                 mode_q;
  logic [IW-1:0]        trefi_q;
  logic                 trefi_tick;
  logic [NUM_RANKS-1:0] usr_inc, inc, dec, pend_mask;
  logic                 ref_evt, zq_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= 1'b0;
    else if (!cfg_ref_en) mode_q <= cfg_user_mode;
  end

  assign usr_ready  = cal_done && mode_q;
  assign trefi_tick = cfg_ref_en && !mode_q && (trefi_q == IW'(TREFI_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !cfg_ref_en || mode_q || trefi_tick) trefi_q <= '0;
    else                                               trefi_q <= trefi_q + 1'b1;
  end

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_port
    rfs_req_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_async (usr_req[r]),
      .ready     (usr_ready),
      .ack       (usr_ack[r]),
      .inc_pulse (usr_inc[r])
    );
  end

  assign inc = trefi_tick ? '1 : usr_inc;

  rfs_pend_cnt #(.NUM_RANKS(NUM_RANKS), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (inc),
    .dec       (dec),
    .pend_mask (pend_mask)
  );

  rfs_sequencer #(
    .NUM_RANKS (NUM_RANKS),
    .RANK_W    (RANK_W),
    .GATE_CYC  (GATE_CYC),
    .TRP_CYC   (TRP_CYC),
    .TRFC_CYC  (TRFC_CYC),
    .ZQ_CYC    (ZQ_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (cfg_ref_en),
    .user_mode (mode_q),
    .zq_block  (zq_block),
    .pend_mask (pend_mask),
    .dec       (dec),
    .block     (rank_block),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_rank  (cmd_rank),
    .ref_evt   (ref_evt),
    .zq_evt    (zq_evt)
  );
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_q,
  input logic                 zq_block,
  input logic                 usr_ready,
  input logic [NUM_RANKS-1:0] usr_ack,
  input logic [NUM_RANKS-1:0] rank_block,
  input logic                 cmd_valid,
  input logic [1:0]           cmd_op,
  input logic [RANK_W-1:0]    cmd_rank
);
  logic [1:0]        last_op_q;
  logic [RANK_W-1:0] last_rk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_op_q <= 2'd0;
      last_rk_q <= '0;
    end else if (cmd_valid) begin
      last_op_q <= cmd_op;
      last_rk_q <= cmd_rank;
    end
  end

  assert_block_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rank_block));

  assert_cmd_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd2)) |-> rank_block[cmd_rank]);

  assert_ref_after_prea_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2) |-> (last_op_q == 2'd1 && last_rk_q == cmd_rank));

  assert_zq_unblocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> !$past(zq_block));

  assert_no_zq_internal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> mode_q);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_ack
    assert_ack_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(usr_ack[r]) |-> $past(usr_ready));
  end
endmodule

bind rank_refresh_sched rfs_sched_chk #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_q     (mode_q),
  .zq_block   (zq_block),
  .usr_ready  (usr_ready),
  .usr_ack    (usr_ack),
  .rank_block (rank_block),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_rank   (cmd_rank)
);

// File: tb/tb_rank_refresh_sched.sv
module tb_rank_refresh_sched;
  localparam int NR = 4;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_ref_en, cfg_user_mode, cal_done, zq_block;
  logic [NR-1:0] usr_req;
  logic [NR-1:0] usr_ack, rank_block;
  logic          usr_ready, cmd_valid;
  logic [1:0]    cmd_op;
  logic [RW-1:0] cmd_rank;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  int   cyc   = 0;
  logic [3:0] exp_q[$];

  always #2 clk = ~clk;

  rank_refresh_sched #(
    .NUM_RANKS(NR), .CNT_W(3), .TREFI_CYC(300), .GATE_CYC(3),
    .TRP_CYC(4), .TRFC_CYC(20), .ZQ_CYC(10)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cfg_ref_en(cfg_ref_en), .cfg_user_mode(cfg_user_mode),
    .cal_done(cal_done), .zq_block(zq_block), .usr_req(usr_req), .usr_ack(usr_ack),
    .usr_ready(usr_ready), .rank_block(rank_block), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_rank(cmd_rank)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Driver side of the scoreboard: one expected refresh (PREA, REF, optional ZQ).
  task automatic expect_refresh(input int rk, input bit with_zq);
    exp_q.push_back({2'd1, RW'(rk)});
    exp_q.push_back({2'd2, RW'(rk)});
    if (with_zq) exp_q.push_back({2'd3, RW'(rk)});
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Full four-phase handshake; checks acknowledge latency (R3) and release (R4).
  task automatic handshake(input int rk, input int hold);
    int waited;
    usr_req[rk] = 1'b1;
    waited = 0;
    while (!usr_ack[rk] && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check(usr_ack[rk] && waited <= 16, "R3 ack latency", waited, 16);
    cycles(hold);
    check(usr_ack[rk] == 1'b1, "R4 ack held while req high", usr_ack[rk], 1);
    usr_req[rk] = 1'b0;
    waited = 0;
    while (usr_ack[rk] && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    check(!usr_ack[rk], "R4 ack falls after req low", usr_ack[rk], 0);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected command", {cmd_op, cmd_rank}, 0);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check({cmd_op, cmd_rank} == e, "R6/R7 command order", {cmd_op, cmd_rank}, e);
        if (cmd_op != 2'd3)
          check(rank_block[cmd_rank] == 1'b1, "R6 rank blocked", rank_block, 1 << cmd_rank);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_ref_en = 1'b0; cfg_user_mode = 1'b0;
    cal_done = 1'b0; zq_block = 1'b0; usr_req = '0;
    cycles(5);
    check(cmd_valid == 0, "R1 cmd_valid reset", cmd_valid, 0);
    check(rank_block == 0, "R1 rank_block reset", rank_block, 0);
    check(usr_ack == 0, "R1 usr_ack reset", usr_ack, 0);
    rst_n = 1'b1;
    cal_done = 1'b1;
    cycles(2);
    check(usr_ready == 0, "R1 internal mode after reset", usr_ready, 0);

    // Disable, switch to user, re-enable.
    cfg_user_mode = 1'b1;
    cycles(2);
    cfg_ref_en = 1'b1;
    cycles(2);
    check(usr_ready == 1, "R2 ready in user mode", usr_ready, 1);
    cfg_user_mode = 1'b0;
    cycles(3);
    check(usr_ready == 1, "R10 mode change while enabled ignored", usr_ready, 1);
    cfg_user_mode = 1'b1;

    // Single request, rank 2.
    expect_refresh(2, 1);
    handshake(2, 2);
    cycles(80);
    drained("R3 single request serviced");

    // Round robin: queue 1,3,0 while disabled; service order from rank 3.
    cfg_ref_en = 1'b0;
    handshake(1, 0);
    handshake(3, 0);
    handshake(0, 0);
    expect_refresh(3, 1);
    expect_refresh(0, 1);
    expect_refresh(1, 1);
    cfg_ref_en = 1'b1;
    cycles(160);
    drained("R7 round-robin order");

    // Held request gives one refresh only.
    expect_refresh(0, 1);
    handshake(0, 60);
    cycles(60);
    drained("R4 held request single refresh");

    // Saturation: nine requests, seven refreshes.
    cfg_ref_en = 1'b0;
    for (int i = 0; i < 9; i++) handshake(1, 0);
    for (int i = 0; i < 7; i++) expect_refresh(1, 1);
    cfg_ref_en = 1'b1;
    cycles(330);
    drained("R8 saturation at seven");

    // ZQ blocked.
    zq_block = 1'b1;
    expect_refresh(2, 0);
    handshake(2, 0);
    cycles(80);
    drained("R11 zq dropped when blocked");
    zq_block = 1'b0;

    // Not ready: no ack, no commands.
    cal_done = 1'b0;
    cycles(1);
    check(usr_ready == 0, "R2 ready low without cal_done", usr_ready, 1'b0);
    usr_req[3] = 1'b1;
    cycles(20);
    check(usr_ack[3] == 0, "R5 no ack when not ready", usr_ack[3], 0);
    usr_req[3] = 1'b0;
    cycles(10);
    cal_done = 1'b1;
    cycles(60);
    drained("R5 no refresh when not ready");

    // Internal mode: one interval tick refreshes all ranks from rank 3.
    cfg_ref_en = 1'b0;
    cfg_user_mode = 1'b0;
    cycles(2);
    cfg_ref_en = 1'b1;
    cycles(1);
    check(usr_ready == 0, "R9 user port closed in internal mode", usr_ready, 0);
    expect_refresh(3, 0);
    expect_refresh(0, 0);
    expect_refresh(1, 0);
    expect_refresh(2, 0);
    cycles(470);
    cfg_ref_en = 1'b0;
    cycles(60);
    drained("R9 interval refresh of every rank");

    summary();
  end
endmodule